// File: doc/BRIEF.md
# I2C Register-Access Slave

This block connects a two-wire serial bus to an internal byte-wide register bank. It only ever answers as a slave and never drives the clock line. It samples both bus lines in the system clock domain and pulls the data line low through a single output-enable pin. On the register side it presents a pointer, write data, a write pulse, a read pulse and a read-data return.

The master first writes the address byte, then a register pointer, then any number of data bytes. To read, it writes the address and the pointer, issues a repeated START, and sends the address again with the read flag set. The slave then returns bytes until the master answers with a NACK. A configuration input decides whether the pointer steps forward after each byte or stays fixed.

The slave address has a fixed five-bit prefix. Its two low bits come from a strap input that is captured while reset is held.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits are 1101 0 followed by the two strap bits, MSB first; bit 0 of that byte is the direction, 1 for read and 0 for write.
- R2: An address byte that does not match gets no acknowledge. The bytes that follow raise no write or read pulse and leave SDA released until the next START or STOP.
- R3: The strap bits are sampled only while rst_n is low. A change on the strap input after reset does not change the address the slave answers to.
- R4: In a write, the byte after the address sets the pointer and every following byte gives one reg_wr pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. Each of these bytes is acknowledged.
- R5: With auto_inc_en high, the pointer advances by one after each data byte, written or read, and wraps from 0xFF to 0x00.
- R6: With auto_inc_en low, every data byte of one transaction uses the same register.
- R7: After a repeated START with the read flag set, the slave shifts out MSB first the value of reg_rdata, sampled in the cycle reg_rd is high, for the current pointer. The pointer survives the repeated START.
- R8: In a read, a master ACK leads to one reg_rd pulse for the next byte. After a NACK the slave releases SDA, so further clocks read 0xFF, and it raises no reg_rd until a START.
- R9: A STOP releases SDA and ends the transaction; a later START begins a new address phase.
- R10: reg_wr and reg_rd are single-cycle pulses and are never high together.
- R11: Out of reset, sda_oe, reg_wr and reg_rd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| addr_strap | input | 2 | Address-select bits, captured during reset |
| auto_inc_en | input | 1 | Enables pointer advance after each data byte |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Data for a register write |
| reg_wr | output | 1 | Register write pulse |
| reg_rd | output | 1 | Register read pulse |
| reg_rdata | input | 8 | Register read data, sampled while reg_rd is high |

## Verification
A corrupted pointer or byte counter shows up within one transaction. Bytes land in the wrong registers of the bench model, or a read returns a neighbour's value. Either error is seen at the next read-back. A wrong bus state shows on the acknowledge slot of the very next byte: a missing or extra low on SDA. It also shows as a stray strobe counted on the register port, or as SDA held low when the master tries to issue a STOP.

// File: rtl/i2cs_pkg.sv
// Shared constants and the bus-state type for the I2C register slave.
package i2cs_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          CNT_W      = $clog2(BYTE_W + 1);
    localparam int          PREFIX_W   = 5;
    localparam int          STRAP_W    = 2;
    localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
// Synchronises SCL/SDA into clk and derives SCL edges and START/STOP events.
// Assumes clk runs many times faster than SCL; outputs are one-cycle flags.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Synchroniser chains plus one history flop per line; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_addr_match.sv
// Captures the address strap during reset and compares an address byte.
// Assumes the byte is MSB-first with the direction bit in bit 0.
module i2cs_addr_match
    import i2cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [BYTE_W-1:0]  addr_byte,
    output logic               addr_hit,
    output logic [STRAP_W-1:0] strap_q
);
    // Strap is loaded only while reset is asserted and held afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= addr_strap;
        end
    end

    assign addr_hit = (addr_byte[BYTE_W-1:1] == {ADDR_PREFIX, strap_q});
endmodule

// File: rtl/i2cs_engine.sv
// Byte-level protocol engine: address, pointer, write data, read data, ACKs.
// Assumes single-cycle event flags from the line synchroniser and a register
// bank whose read data is valid in the same cycle as reg_rd.
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_hit,
    input  logic              auto_inc_en,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] shreg_o,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              rw;
    logic              mack;
    logic              byte_done;

    assign byte_done = scl_fall && (bitcnt == FULL);

    // Main sequencer: START/STOP override, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_PTR_ACK;
                            end else begin
                                reg_wdata <= shreg;
                                reg_wr    <= 1'b1;
                                sda_oe    <= 1'b1;
                                state     <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                reg_rd <= 1'b1;
                                state  <= ST_RD_LOAD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (state == ST_WR_ACK && auto_inc_en) begin
                                ptr <= ptr + 1'b1;
                            end
                            state <= ST_WDATA;
                        end
                    end
                    ST_RD_LOAD: begin
                        shreg  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        state  <= ST_RDATA;
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                            if (!sda_s && auto_inc_en) begin
                                ptr <= ptr + 1'b1;
                            end
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                reg_rd <= 1'b1;
                                state  <= ST_RD_LOAD;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign shreg_o  = shreg;
    assign reg_addr = ptr;
endmodule

// File: rtl/i2c_reg_slave.sv
// Top level of the I2C register-access slave: synchroniser, address match
// and protocol engine. Assumes an external open-drain pad driven by sda_oe.
module i2c_reg_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic               auto_inc_en,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_wr,
    output logic               reg_rd,
    input  logic [BYTE_W-1:0]  reg_rdata
);
    logic               sda_s;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    logic               addr_hit;
    logic [BYTE_W-1:0]  shreg;
    logic [STRAP_W-1:0] strap_q;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_addr_match u_match (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
        .addr_byte(shreg), .addr_hit(addr_hit), .strap_q(strap_q)
    );

    i2cs_engine u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_hit(addr_hit), .auto_inc_en(auto_inc_en), .reg_rdata(reg_rdata),
        .shreg_o(shreg), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd)
    );
endmodule

// File: rtl/i2cs_checker.sv
// Protocol properties for i2c_reg_slave, attached by bind below.
module i2cs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] strap_q
);
    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    assert_wr_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(scl_fall));
    assert_rd_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> $past(scl_fall));
    assert_sda_moves_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |->
            ($past(scl_fall) || $past(scl_fall, 2) || $past(start_det) || $past(stop_det)));
    assert_strap_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

bind i2c_reg_slave i2cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .strap_q(strap_q)
);

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
module test_i2c_reg_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       auto_inc = 1'b0;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_wr, reg_rd, sda_oe;
    logic       sda_line;

    logic [7:0] regs [256];
    logic [7:0] exp_mem [256];
    logic [7:0] buf_q [8];
    int         n_tests = 0;
    int         n_fail = 0;
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    int         pulse_err = 0;
    logic       wr_d = 1'b0, rd_d = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_reg_slave i_i2c_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .auto_inc_en(auto_inc), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Register bank model driven only by the port strobes.
    always @(posedge clk) begin
        if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if ((reg_wr && reg_rd) || (reg_wr && wr_d) || (reg_rd && rd_d)) pulse_err <= pulse_err + 1;
        wr_d <= reg_wr;
        rd_d <= reg_rd;
    end

    function automatic logic [7:0] exp_addr(input logic [7:0] p, input int i, input bit au);
        return au ? 8'(p + i) : p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        acked = ~sda_line;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Write n bytes of buf_q starting at pointer p, then compare the bank.
    task automatic write_tx(input logic [6:0] sa, input logic [7:0] p, input int n, input bit au);
        bit ack;
        auto_inc = au;
        bus_start();
        send_byte({sa, 1'b0}, ack); check(ack, "R1 addr ack", ack, 1);
        send_byte(p, ack);          check(ack, "R4 ptr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(buf_q[i], ack); check(ack, "R4 data ack", ack, 1);
            exp_mem[exp_addr(p, i, au)] = buf_q[i];
        end
        bus_stop();
        tick(2);
        for (int i = 0; i < n; i++) begin
            check(regs[exp_addr(p, i, au)] == exp_mem[exp_addr(p, i, au)],
                  au ? "R5 write autoinc" : "R6 write fixed",
                  regs[exp_addr(p, i, au)], exp_mem[exp_addr(p, i, au)]);
        end
    endtask

    // Read n bytes from pointer p via repeated START, NACK on the last.
    task automatic read_tx(input logic [6:0] sa, input logic [7:0] p, input int n, input bit au);
        bit ack;
        logic [7:0] b;
        int rd0;
        auto_inc = au;
        bus_start();
        send_byte({sa, 1'b0}, ack);
        send_byte(p, ack);
        scl = 1'b0; sda_m = 1'b1; tick(Q);
        bus_start();
        rd0 = rd_cnt;
        send_byte({sa, 1'b1}, ack); check(ack, "R1 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            check(b == exp_mem[exp_addr(p, i, au)], au ? "R7 R5 read data" : "R7 R6 read data",
                  b, exp_mem[exp_addr(p, i, au)]);
        end
        check(rd_cnt - rd0 == n, "R8 read strobes", rd_cnt - rd0, n);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int w0, r0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin regs[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
        tick(6);
        check(!sda_oe && !reg_wr && !reg_rd, "R11 reset outputs", {sda_oe, reg_wr, reg_rd}, 0);
        rst_n = 1'b1;
        tick(4);
        strap = 2'b01;  // R3: change after reset must be ignored
        check(!sda_oe && !reg_wr && !reg_rd, "R11 post reset idle", {sda_oe, reg_wr, reg_rd}, 0);

        // R4 R5: auto-increment write and read back
        buf_q[0] = 8'hA1; buf_q[1] = 8'h5C; buf_q[2] = 8'h00;
        write_tx(7'h6A, 8'h10, 3, 1'b1);
        read_tx(7'h6A, 8'h10, 3, 1'b1);

        // R5: pointer wrap 0xFF -> 0x00
        buf_q[0] = 8'h3E; buf_q[1] = 8'hC7;
        write_tx(7'h6A, 8'hFF, 2, 1'b1);
        check(regs[0] == 8'hC7, "R5 wrap", regs[0], 8'hC7);

        // R6: fixed pointer, last byte wins, neighbour untouched
        buf_q[0] = 8'h11; buf_q[1] = 8'h22; buf_q[2] = 8'h33;
        write_tx(7'h6A, 8'h40, 3, 1'b0);
        check(regs[8'h41] == exp_mem[8'h41], "R6 neighbour untouched", regs[8'h41], exp_mem[8'h41]);
        read_tx(7'h6A, 8'h40, 3, 1'b0);

        // R8: NACK ends data phase
        r0 = rd_cnt;
        auto_inc = 1'b1;
        bus_start();
        send_byte(8'hD5, ack);  // 0x6A read
        recv_byte(b, 1'b0);
        recv_byte(b, 1'b0);
        check(b == 8'hFF, "R8 released after nack", b, 8'hFF);
        check(rd_cnt - r0 == 1, "R8 no read after nack", rd_cnt - r0, 1);
        bus_stop();

        // R2 R3: mismatched address, including the new strap value
        w0 = wr_cnt;
        auto_inc = 1'b0;
        bus_start();
        send_byte(8'hD2, ack);  // 0x69 write: strap changed after reset
        check(!ack, "R3 strap not resampled", ack, 0);
        send_byte(8'h05, ack);
        check(!ack, "R2 ignored ptr", ack, 0);
        send_byte(8'h99, ack);
        bus_stop();
        bus_start();
        send_byte(8'hE6, ack);  // prefix mismatch
        check(!ack, "R2 prefix mismatch", ack, 0);
        send_byte(8'h77, ack);
        bus_stop();
        tick(2);
        check(wr_cnt == w0, "R2 no writes", wr_cnt - w0, 0);

        // R9: STOP after pointer, SDA released, next transaction works
        bus_start();
        send_byte(8'hD4, ack);
        send_byte(8'h20, ack);
        bus_stop();
        tick(4);
        check(sda_line == 1'b1 && !sda_oe, "R9 released after stop", sda_oe, 0);
        buf_q[0] = 8'h5A;
        write_tx(7'h6A, 8'h20, 1, 1'b0);

        // Random transactions checked against the bench model
        for (int k = 0; k < 16; k++) begin
            logic [7:0] p;
            int n;
            bit au;
            p  = 8'($urandom);
            n  = 1 + int'($urandom % 4);
            au = 1'($urandom);
            for (int i = 0; i < n; i++) buf_q[i] = 8'($urandom);
            write_tx(7'h6A, p, n, au);
            read_tx(7'h6A, p, n, 1'($urandom));
        end

        check(pulse_err == 0, "R10 strobe shape", pulse_err, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule